// File: doc/BRIEF.md
# Dual-Channel Serial DAC Register Interface

This block is the digital front end of a two-channel 12-bit converter that is loaded over a serial link. A host drives a serial clock, a data line, an active-low select and an active-low load strobe. While select is low, each rising serial-clock edge moves one data bit into a 24-bit frame register that holds the codes for both channels. Two 12-bit channel latches copy that frame register whenever select is high and the load strobe is low. If the strobe is tied low (three-wire use), releasing select loads both channels.

The frame register also drives a serial output, so several devices can be chained or the host can read back what it wrote. A bit leaves the register 24 rising edges after it entered. The output is modelled as an open-drain line with two signals: a driver-enable and a pull-down request. All serial pins are brought into the system clock domain through synchronisers, and every decision is made on that clock. The serial clock must therefore run well below the system clock.

Top module: `dual_dac_serial_if`

## Requirements
- R1: While `rst` is high and just after it falls, both channel codes are zero, the frame register is zero (the first readback frame returns 24 zero bits), and the output line is released (`sdo_en`=0, `sdo_pd`=0).
- R2: While `sel_n` is low, each rising edge of `ser_clk` shifts the level on `ser_din` into bit 0 of the 24-bit frame register, and the older bits move one place toward bit 23.
- R3: The first bit sent in a frame is the MSB of channel B. After 24 bits, frame bits 23..12 are the channel B code and bits 11..0 are the channel A code, each sent MSB first.
- R4: While `sel_n` is high and `load_n` is low, both latches follow the frame register. While `load_n` is high, the latches keep their value.
- R5: With `load_n` held low for the whole frame, the rise of `sel_n` loads the new frame into both latches.
- R6: While `sel_n` is low, a low `load_n` does not change either latch.
- R7: Edges on `ser_clk` while `sel_n` is high leave the frame register unchanged.
- R8: The output driver is enabled (`sdo_en`=1) while `sel_n` is low and released while it is high. While it is released, `sdo_pd` is 0. While it is enabled, `sdo_pd` is 1 exactly when the bit presented is 0.
- R9: When `sel_n` falls, the output presents frame bit 23. After each falling edge of `ser_clk`, it presents the new bit 23. The bit shifted in on the k-th rising edge therefore appears after the falling edge that follows rising edge k+23.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| ser_clk | input | 1 | Serial clock, asynchronous to clk |
| ser_din | input | 1 | Serial data input |
| sel_n | input | 1 | Active-low device select |
| load_n | input | 1 | Active-low latch load strobe |
| code_a | output | 12 | Latched channel A code |
| code_b | output | 12 | Latched channel B code |
| sdo_en | output | 1 | Serial output driver enabled |
| sdo_pd | output | 1 | Serial output pull-down active (line low) |

## Verification
Properties are checked on every cycle:
- Shift direction.
- Freezing of the frame register while deselected.
- Latches copy the frame exactly when the update condition holds, and hold otherwise.
- No pull-down while the driver is released.

Only the bench scenarios can show the rest:
- Bit order and channel split of a whole frame.
- The 24-edge readback delay.
- Three-wire loading on the select rise.
- Stray clocks while deselected leave no trace in later latch or readback values.

// File: rtl/dac_if_pkg.sv
package dac_if_pkg;
  // serial clock events seen in the system clock domain
  typedef struct packed {
    logic rise;
    logic fall;
  } sclk_evt_t;

  function automatic sclk_evt_t detect_edges(input logic now_lvl, input logic prev_lvl);
    sclk_evt_t e;
    e.rise = now_lvl & ~prev_lvl;
    e.fall = ~now_lvl & prev_lvl;
    return e;
  endfunction
endpackage

// File: rtl/dac_sync.sv
module dac_sync #(
  parameter int unsigned W = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= RST_VAL;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dac_shift_core.sv
module dac_shift_core #(
  parameter int unsigned FRAME_W = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel_n_s,
  input  logic               sclk_rise,
  input  logic               sclk_fall,
  input  logic               sel_fell,
  input  logic               din_s,
  output logic [FRAME_W-1:0] frame,
  output logic               line_en,
  output logic               line_pd
);
  logic shift_en;
  logic present_upd;
  logic out_bit;
  logic next_bit;

  assign shift_en    = sclk_rise & ~sel_n_s;
  assign present_upd = sel_fell | (sclk_fall & ~sel_n_s);
  assign next_bit    = present_upd ? frame[FRAME_W-1] : out_bit;

  always_ff @(posedge clk) begin
    if (rst)           frame <= '0;
    else if (shift_en) frame <= {frame[FRAME_W-2:0], din_s};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_bit <= 1'b1;
      line_en <= 1'b0;
      line_pd <= 1'b0;
    end else begin
      out_bit <= next_bit;
      line_en <= ~sel_n_s;
      line_pd <= ~sel_n_s & ~next_bit;
    end
  end

  // R2: one-place shift toward the MSB on a selected rising edge
  p_shift_dir_r2: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> frame[FRAME_W-1:1] == $past(frame[FRAME_W-2:0]));

  // R7: deselected, the frame register is frozen
  p_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    sel_n_s |=> $stable(frame));

  // R8: never pull the line while the driver is released
  p_release_r8: assert property (@(posedge clk) disable iff (rst)
    !line_en |-> !line_pd);
endmodule

// File: rtl/dac_latch_bank.sv
module dac_latch_bank #(
  parameter int unsigned CODE_W   = 12,
  parameter int unsigned CHANNELS = 2,
  localparam int unsigned FRAME_W = CODE_W * CHANNELS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               upd,
  input  logic [FRAME_W-1:0] frame,
  output logic [FRAME_W-1:0] codes
);
  for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
    always_ff @(posedge clk) begin
      if (rst)      codes[c*CODE_W +: CODE_W] <= '0;
      else if (upd) codes[c*CODE_W +: CODE_W] <= frame[c*CODE_W +: CODE_W];
    end
  end

  // R4: latches copy the frame when the update condition holds
  p_copy_r4: assert property (@(posedge clk) disable iff (rst)
    upd |=> codes == $past(frame));

  // R4: latches hold otherwise
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(codes));
endmodule

// File: rtl/dual_dac_serial_if.sv
module dual_dac_serial_if #(
  parameter int unsigned CODE_W      = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk,
  input  logic              ser_din,
  input  logic              sel_n,
  input  logic              load_n,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b,
  output logic              sdo_en,
  output logic              sdo_pd
);
  import dac_if_pkg::*;

  localparam int unsigned CHANNELS = 2;
  localparam int unsigned FRAME_W  = CODE_W * CHANNELS;

  logic [3:0]         pins_s;
  logic               sclk_s, din_s, sel_n_s, load_n_s;
  logic               sclk_q, sel_n_q;
  sclk_evt_t          evt;
  logic               sel_fell;
  logic               upd;
  logic [FRAME_W-1:0] frame;
  logic [FRAME_W-1:0] codes;

  dac_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0011)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ser_clk, ser_din, sel_n, load_n}),
    .q   (pins_s)
  );

  assign {sclk_s, din_s, sel_n_s, load_n_s} = pins_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q  <= 1'b0;
      sel_n_q <= 1'b1;
    end else begin
      sclk_q  <= sclk_s;
      sel_n_q <= sel_n_s;
    end
  end

  assign evt      = detect_edges(sclk_s, sclk_q);
  assign sel_fell = ~sel_n_s & sel_n_q;
  assign upd      = sel_n_s & ~load_n_s;

  dac_shift_core #(.FRAME_W(FRAME_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .sel_n_s   (sel_n_s),
    .sclk_rise (evt.rise),
    .sclk_fall (evt.fall),
    .sel_fell  (sel_fell),
    .din_s     (din_s),
    .frame     (frame),
    .line_en   (sdo_en),
    .line_pd   (sdo_pd)
  );

  dac_latch_bank #(.CODE_W(CODE_W), .CHANNELS(CHANNELS)) u_latch (
    .clk   (clk),
    .rst   (rst),
    .upd   (upd),
    .frame (frame),
    .codes (codes)
  );

  // channel A sits in the low half, channel B (sent first) in the high half
  assign code_a = codes[CODE_W-1:0];
  assign code_b = codes[FRAME_W-1:CODE_W];

  // R6: a selected device never changes its outputs' codes
  p_gate_r6: assert property (@(posedge clk) disable iff (rst)
    !sel_n_s |=> $stable({code_b, code_a}));

  // R8: driver enable follows the synchronised select
  p_enable_r8: assert property (@(posedge clk) disable iff (rst)
    !sel_n_s |=> sdo_en);
endmodule

// File: tb/dual_dac_serial_if_tb.sv
`timescale 1ns/1ps
module dual_dac_serial_if_tb;
  localparam int HP = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic ser_clk = 1'b0, ser_din = 1'b0, sel_n = 1'b1, load_n = 1'b1;
  logic [11:0] code_a, code_b;
  logic sdo_en, sdo_pd;

  int n_cmp = 0, n_bad = 0;
  logic [23:0] mdl = '0;      // expected frame register
  logic [23:0] lat = '0;      // expected latched codes {B,A}
  logic [23:0] last_rd = '0;  // bits read back in the last frame

  always #2.5 clk = ~clk;

  dual_dac_serial_if u_dut (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_din(ser_din),
    .sel_n(sel_n), .load_n(load_n), .code_a(code_a), .code_b(code_b),
    .sdo_en(sdo_en), .sdo_pd(sdo_pd)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [23:0] w, input bit three);
    logic [23:0] rd;
    rd = '0;
    sel_n = 1'b0;
    if (three) load_n = 1'b0;
    wt(HP);
    chk("R8 enable", {31'd0, sdo_en}, 32'd1);
    rd[23] = ~sdo_pd;
    for (int i = 23; i >= 0; i--) begin
      ser_din = w[i];
      wt(HP); ser_clk = 1'b1;
      wt(HP); ser_clk = 1'b0;
      wt(HP);
      if (i > 0) rd[i-1] = ~sdo_pd;
      else chk("R9 delayed bit", {31'd0, ~sdo_pd}, {31'd0, w[23]});
    end
    last_rd = rd;
    chk("R2,R9 readback", {8'd0, rd}, {8'd0, mdl});
    if (three) chk("R6 no load while selected", {8'd0, code_b, code_a}, {8'd0, lat});
    mdl = w;
    sel_n = 1'b1;
    wt(HP);
    chk("R8 released", {30'd0, sdo_en, sdo_pd}, 32'd0);
    if (three) begin
      lat = w;
      chk("R5 load on select rise", {8'd0, code_b, code_a}, {8'd0, w});
      load_n = 1'b1;
      wt(HP);
    end else begin
      chk("R4 hold while load high", {8'd0, code_b, code_a}, {8'd0, lat});
    end
  endtask

  task automatic pulse_load();
    load_n = 1'b0;
    wt(HP);
    lat = mdl;
    chk("R4 load", {8'd0, code_b, code_a}, {8'd0, mdl});
    chk("R3 channel B", {20'd0, code_b}, {20'd0, mdl[23:12]});
    chk("R3 channel A", {20'd0, code_a}, {20'd0, mdl[11:0]});
    load_n = 1'b1;
    wt(HP);
  endtask

  task automatic stray_clocks(input int n);
    for (int k = 0; k < n; k++) begin
      ser_din = k[0];
      wt(HP); ser_clk = 1'b1;
      wt(HP); ser_clk = 1'b0;
    end
    wt(HP);
  endtask

  initial begin
    wt(10);
    chk("R1 reset codes", {8'd0, code_b, code_a}, 32'd0);
    chk("R1 reset line", {30'd0, sdo_en, sdo_pd}, 32'd0);
    rst = 1'b0;
    wt(HP);
    chk("R1 codes after reset", {8'd0, code_b, code_a}, 32'd0);

    frame(24'hABC123, 1'b0);
    chk("R1 cleared frame register", {8'd0, last_rd}, 32'd0);
    pulse_load();

    stray_clocks(10);
    pulse_load();
    chk("R7 latches unchanged", {8'd0, code_b, code_a}, 32'h00ABC123);
    frame(24'h5A5F0F, 1'b0);
    chk("R7 readback unchanged", {8'd0, last_rd}, 32'h00ABC123);
    pulse_load();

    // sweep over arithmetic patterns, alternating three- and four-wire use
    for (int j = 0; j < 16; j++) begin
      logic [11:0] b, a;
      b = 12'(j * 12'h111) ^ (j[1] ? 12'hFFF : 12'h000);
      a = ~12'(j * 12'h0F1);
      frame({b, a}, j[0]);
      if (!j[0]) pulse_load();
    end

    // boundary codes
    frame(24'hFFFFFF, 1'b0); pulse_load();
    frame(24'h8007FF, 1'b1);
    frame(24'h7FF800, 1'b0); pulse_load();
    frame(24'h000000, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule